// File: doc/BRIEF.md
# Direct-Mapped Page Translation Cache

This block holds recently used virtual-page to host-page translations in a small direct-mapped table. It sits in front of the slower segment decoder and TLB logic. Every access folds part of the virtual page number into a table index and compares the stored page tag with the incoming page. On a hit, the block returns the target address one cycle after it accepts the access. On a miss, it raises a request to the slow path, stalls until the answer arrives, writes that answer into the indexed slot and completes the access from it.

A slot can be marked as device-mapped or as copy-on-write. A device slot keeps a packed device identifier and device offset in place of a memory page base. The block splits this field and reports the two parts on dedicated outputs. A write that lands on a copy-on-write slot always goes to the slow path, even when the tag hits. A translate-only query returns just the guest physical page number. When it misses, it asks the slow path for a quiet lookup that raises no exception.

The cache works in one of two address modes, 64-bit or 32-bit. Switching to the other mode discards every slot. Writing the mode that is already in force changes nothing. The block takes one access at a time.

Top module: `xlate_cache`

## Requirements
- R1: After reset, `req_ready` is 1, `resp_valid` and `sp_req_valid` are 0, the mode is 64-bit, and every slot is empty, so the first access to any page misses.
- R2: The slot index is vaddr[17:12] XOR vaddr[23:18]. An access hits when the slot is valid and its tag equals the vaddr page number. A hit raises `resp_valid` on the clock edge after acceptance, raises no slow-path request, and gives `resp_addr` = stored host base + vaddr[11:0].
- R3: A write access (`req_write`=1, `req_xlate`=0) to a slot whose copy-on-write flag is set takes the miss path even when the tag matches. The refill then replaces the slot.
- R4: On a miss, `sp_req_valid` rises on the clock edge after acceptance. It carries the access vaddr, write and translate bits, and holds them stable until `sp_rsp_valid`. On that edge the slot is rewritten and `resp_valid` rises. A later access to the same page hits.
- R5: If the slow path answers with `sp_rsp_fail`=1, the response has `resp_err`=1 and `resp_addr`, `resp_dev` and `resp_ppn` are zero. The slot is not written, so the next access to that page misses again.
- R6: For a device slot on a non-translate access, `resp_dev`=1 and `resp_addr`=0. `resp_dev_id` is stored host bits [39:32] and `resp_dev_off` is stored host bits [31:0].
- R7: A translate-only access (`req_xlate`=1) returns the stored guest physical page number on `resp_ppn`, with `resp_addr`=0 and `resp_dev`=0. On a miss it drives `sp_req_xlate`=1.
- R8: In 32-bit mode (`mode_sel64`=0) only vaddr[31:12] takes part in the tag. Two addresses that differ only in bits [63:32] share a slot and hit on each other. In 64-bit mode, bits [63:12] all count.
- R9: A `mode_wr` pulse with a mode different from the current one clears every slot. A pulse with the current mode leaves the slots untouched.
- R10: Exactly one access is in flight. `req_ready` is 0 while a miss waits, and `resp_valid` is never high together with `sp_req_valid`.
- R11: Two pages with the same index and different tags evict each other. Accessing one after the other misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wr | input | 1 | Mode write strobe |
| mode_sel64 | input | 1 | Mode to write: 1 = 64-bit, 0 = 32-bit |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Block can accept an access |
| req_write | input | 1 | Access is a write |
| req_xlate | input | 1 | Translate-only query |
| req_vaddr | input | 64 | Virtual address |
| resp_valid | output | 1 | Response strobe, one cycle |
| resp_err | output | 1 | Slow path failed |
| resp_dev | output | 1 | Access routed to a device |
| resp_addr | output | 40 | Host memory address |
| resp_dev_id | output | 8 | Device identifier |
| resp_dev_off | output | 32 | Device offset |
| resp_ppn | output | 24 | Guest physical page number |
| sp_req_valid | output | 1 | Slow-path lookup request |
| sp_req_vaddr | output | 64 | Address to resolve |
| sp_req_write | output | 1 | Pending access is a write |
| sp_req_xlate | output | 1 | Quiet lookup, no exceptions |
| sp_rsp_valid | input | 1 | Slow-path answer strobe |
| sp_rsp_fail | input | 1 | Slow path found no mapping |
| sp_rsp_host | input | 40 | Host page base or packed device field |
| sp_rsp_gppn | input | 24 | Guest physical page number |
| sp_rsp_dev | input | 1 | Mapping is a device |
| sp_rsp_cow | input | 1 | Mapping is copy-on-write |

## Verification
The hardest state to reach from the ports is a copy-on-write slot whose tag hits but is still forced onto the slow path on a write. Reads of the same page must keep hitting it. The stimulus refills a page with the copy-on-write flag set and reads it back to confirm a hit. It then writes the same page, expects a slow-path request, and answers with the flag cleared so that a second write hits. The mode flush is reached in a similar way. A page is loaded, both a repeated and a changed mode are written, and the slow-path request line shows whether the slot survived.

// File: rtl/tc_pkg.sv
package tc_pkg;
    localparam int VA_W       = 64;
    localparam int PAGE_SHIFT = 12;
    localparam int IDX_W      = 6;
    localparam int HOST_W     = 40;
    localparam int GPA_W      = 36;
    localparam int DEVID_W    = 8;

    localparam int VPN_W    = VA_W - PAGE_SHIFT;
    localparam int GPPN_W   = GPA_W - PAGE_SHIFT;
    localparam int DEVOFF_W = HOST_W - DEVID_W;
    localparam int DEPTH    = 1 << IDX_W;
    localparam int NARROW_W = 32 - PAGE_SHIFT;

    typedef struct packed {
        logic [VPN_W-1:0]  tag;
        logic [HOST_W-1:0] host;
        logic [GPPN_W-1:0] gppn;
        logic              dev;
        logic              cow;
    } tc_entry_t;

    typedef struct packed {
        logic                  err;
        logic                  dev;
        logic                  xlate;
        logic [HOST_W-1:0]     host;
        logic [GPPN_W-1:0]     gppn;
        logic [PAGE_SHIFT-1:0] off;
    } tc_resp_t;

    typedef enum logic {ST_IDLE, ST_WAIT} tc_state_t;

    // Fold two adjacent index-sized groups of page-number bits together.
    function automatic logic [IDX_W-1:0] tc_index(input logic [2*IDX_W-1:0] bits);
        return bits[IDX_W-1:0] ^ bits[2*IDX_W-1:IDX_W];
    endfunction

    // Narrow mode keeps only the page bits below address bit 32.
    function automatic logic [VPN_W-1:0] tc_tag(input logic [VPN_W-1:0] vpn,
                                                input logic wide);
        return wide ? vpn : {{(VPN_W-NARROW_W){1'b0}}, vpn[NARROW_W-1:0]};
    endfunction
endpackage

// File: rtl/tc_entry_store.sv
module tc_entry_store
    import tc_pkg::*;
#(
    parameter int SLOTS = DEPTH,
    localparam int AW   = $clog2(SLOTS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            flush,
    input  logic [AW-1:0]   rd_idx,
    output logic            rd_valid,
    output tc_entry_t       rd_entry,
    input  logic            we,
    input  logic [AW-1:0]   widx,
    input  tc_entry_t       wdata
);
    logic [SLOTS-1:0] vld_q;
    tc_entry_t        ent_q [SLOTS];

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst || flush)
                vld_q[i] <= 1'b0;
            else if (we && widx == AW'(i))
                vld_q[i] <= 1'b1;
        end

        always_ff @(posedge clk) begin
            if (we && widx == AW'(i))
                ent_q[i] <= wdata;
        end
    end

    assign rd_valid = vld_q[rd_idx];
    assign rd_entry = ent_q[rd_idx];

    // R9: a flush leaves no slot valid on the following cycle
    a_r9_flush_clears: assert property (@(posedge clk) disable iff (rst)
        flush |=> (vld_q == '0));
endmodule

// File: rtl/tc_lookup_ctrl.sv
module tc_lookup_ctrl
    import tc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  mode_wr,
    input  logic                  mode_sel64,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic                  req_write,
    input  logic                  req_xlate,
    input  logic [VA_W-1:0]       req_vaddr,
    output logic                  sp_req_valid,
    output logic [VA_W-1:0]       sp_req_vaddr,
    output logic                  sp_req_write,
    output logic                  sp_req_xlate,
    input  logic                  sp_rsp_valid,
    input  logic                  sp_rsp_fail,
    input  logic [HOST_W-1:0]     sp_rsp_host,
    input  logic [GPPN_W-1:0]     sp_rsp_gppn,
    input  logic                  sp_rsp_dev,
    input  logic                  sp_rsp_cow,
    output logic                  flush,
    output logic [IDX_W-1:0]      rd_idx,
    input  logic                  rd_valid,
    input  tc_entry_t             rd_entry,
    output logic                  we,
    output logic [IDX_W-1:0]      widx,
    output tc_entry_t             wdata,
    output logic                  resp_valid,
    output tc_resp_t              resp
);
    tc_state_t        state_q;
    logic             wide_q;
    logic [VA_W-1:0]  pend_va_q;
    logic             pend_wr_q;
    logic             pend_xl_q;
    logic             resp_v_q;
    tc_resp_t         resp_q;

    logic accept, tag_hit, cow_force, fast;

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign flush     = mode_wr && (mode_sel64 != wide_q);

    assign rd_idx    = tc_index(req_vaddr[PAGE_SHIFT +: 2*IDX_W]);
    assign tag_hit   = rd_valid &&
                       (rd_entry.tag == tc_tag(req_vaddr[VA_W-1:PAGE_SHIFT], wide_q));
    assign cow_force = req_write && !req_xlate && rd_entry.cow;
    assign fast      = tag_hit && !cow_force;

    assign sp_req_valid = (state_q == ST_WAIT);
    assign sp_req_vaddr = pend_va_q;
    assign sp_req_write = pend_wr_q;
    assign sp_req_xlate = pend_xl_q;

    assign we         = (state_q == ST_WAIT) && sp_rsp_valid && !sp_rsp_fail;
    assign widx       = tc_index(pend_va_q[PAGE_SHIFT +: 2*IDX_W]);
    assign wdata.tag  = tc_tag(pend_va_q[VA_W-1:PAGE_SHIFT], wide_q);
    assign wdata.host = sp_rsp_host;
    assign wdata.gppn = sp_rsp_gppn;
    assign wdata.dev  = sp_rsp_dev;
    assign wdata.cow  = sp_rsp_cow;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            wide_q    <= 1'b1;
            pend_va_q <= '0;
            pend_wr_q <= 1'b0;
            pend_xl_q <= 1'b0;
            resp_v_q  <= 1'b0;
            resp_q    <= '0;
        end else begin
            resp_v_q <= 1'b0;
            if (flush)
                wide_q <= mode_sel64;
            unique case (state_q)
                ST_IDLE: if (accept) begin
                    pend_va_q <= req_vaddr;
                    pend_wr_q <= req_write;
                    pend_xl_q <= req_xlate;
                    if (fast) begin
                        resp_v_q <= 1'b1;
                        resp_q   <= '{err: 1'b0, dev: rd_entry.dev, xlate: req_xlate,
                                      host: rd_entry.host, gppn: rd_entry.gppn,
                                      off: req_vaddr[PAGE_SHIFT-1:0]};
                    end else begin
                        state_q <= ST_WAIT;
                    end
                end
                ST_WAIT: if (sp_rsp_valid) begin
                    state_q  <= ST_IDLE;
                    resp_v_q <= 1'b1;
                    if (sp_rsp_fail)
                        resp_q <= '{err: 1'b1, dev: 1'b0, xlate: pend_xl_q,
                                    host: '0, gppn: '0, off: '0};
                    else
                        resp_q <= '{err: 1'b0, dev: sp_rsp_dev, xlate: pend_xl_q,
                                    host: sp_rsp_host, gppn: sp_rsp_gppn,
                                    off: pend_va_q[PAGE_SHIFT-1:0]};
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign resp_valid = resp_v_q;
    assign resp       = resp_q;

    // R2: an accepted hit answers next cycle without a slow-path request
    a_r2_hit_fast: assert property (@(posedge clk) disable iff (rst)
        (accept && fast) |=> (resp_valid && !sp_req_valid));
    // R4: a waiting request holds its address until answered
    a_r4_req_hold: assert property (@(posedge clk) disable iff (rst)
        (sp_req_valid && !sp_rsp_valid) |=> (sp_req_valid && $stable(sp_req_vaddr)));
    // R10: a response and a pending slow-path request never coincide
    a_r10_single: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> !sp_req_valid);
endmodule

// File: rtl/tc_resp_format.sv
module tc_resp_format
    import tc_pkg::*;
(
    input  tc_resp_t              resp,
    output logic                  resp_err,
    output logic                  resp_dev,
    output logic [HOST_W-1:0]     resp_addr,
    output logic [DEVID_W-1:0]    resp_dev_id,
    output logic [DEVOFF_W-1:0]   resp_dev_off,
    output logic [GPPN_W-1:0]     resp_ppn
);
    logic to_mem, to_dev;

    always_comb begin
        to_mem       = !resp.err && !resp.xlate && !resp.dev;
        to_dev       = !resp.err && !resp.xlate && resp.dev;
        resp_err     = resp.err;
        resp_dev     = to_dev;
        resp_addr    = to_mem ? (resp.host + HOST_W'(resp.off)) : '0;
        resp_dev_id  = to_dev ? resp.host[HOST_W-1 -: DEVID_W] : '0;
        resp_dev_off = to_dev ? resp.host[DEVOFF_W-1:0] : '0;
        resp_ppn     = (!resp.err && resp.xlate) ? resp.gppn : '0;
    end
endmodule

// File: rtl/xlate_cache.sv
module xlate_cache
    import tc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  mode_wr,
    input  logic                  mode_sel64,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic                  req_write,
    input  logic                  req_xlate,
    input  logic [VA_W-1:0]       req_vaddr,
    output logic                  resp_valid,
    output logic                  resp_err,
    output logic                  resp_dev,
    output logic [HOST_W-1:0]     resp_addr,
    output logic [DEVID_W-1:0]    resp_dev_id,
    output logic [DEVOFF_W-1:0]   resp_dev_off,
    output logic [GPPN_W-1:0]     resp_ppn,
    output logic                  sp_req_valid,
    output logic [VA_W-1:0]       sp_req_vaddr,
    output logic                  sp_req_write,
    output logic                  sp_req_xlate,
    input  logic                  sp_rsp_valid,
    input  logic                  sp_rsp_fail,
    input  logic [HOST_W-1:0]     sp_rsp_host,
    input  logic [GPPN_W-1:0]     sp_rsp_gppn,
    input  logic                  sp_rsp_dev,
    input  logic                  sp_rsp_cow
);
    logic             flush, rd_valid, we;
    logic [IDX_W-1:0] rd_idx, widx;
    tc_entry_t        rd_entry, wdata;
    tc_resp_t         resp;

    tc_entry_store #(.SLOTS(DEPTH)) u_store (
        .clk(clk), .rst(rst), .flush(flush),
        .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_entry(rd_entry),
        .we(we), .widx(widx), .wdata(wdata)
    );

    tc_lookup_ctrl u_ctrl (
        .clk(clk), .rst(rst), .mode_wr(mode_wr), .mode_sel64(mode_sel64),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_xlate(req_xlate), .req_vaddr(req_vaddr),
        .sp_req_valid(sp_req_valid), .sp_req_vaddr(sp_req_vaddr),
        .sp_req_write(sp_req_write), .sp_req_xlate(sp_req_xlate),
        .sp_rsp_valid(sp_rsp_valid), .sp_rsp_fail(sp_rsp_fail),
        .sp_rsp_host(sp_rsp_host), .sp_rsp_gppn(sp_rsp_gppn),
        .sp_rsp_dev(sp_rsp_dev), .sp_rsp_cow(sp_rsp_cow),
        .flush(flush), .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_entry(rd_entry),
        .we(we), .widx(widx), .wdata(wdata),
        .resp_valid(resp_valid), .resp(resp)
    );

    tc_resp_format u_fmt (
        .resp(resp), .resp_err(resp_err), .resp_dev(resp_dev),
        .resp_addr(resp_addr), .resp_dev_id(resp_dev_id),
        .resp_dev_off(resp_dev_off), .resp_ppn(resp_ppn)
    );

    // R5: a failed lookup yields no address and no device routing
    a_r5_err_blank: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_err) |-> (resp_addr == '0 && !resp_dev && resp_ppn == '0));
    // R6: a device-routed response carries no memory address
    a_r6_dev_noaddr: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_dev) |-> (resp_addr == '0));
endmodule

// File: tb/xlate_cache_tb_top.sv
module xlate_cache_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode_wr = 1'b0, mode_sel64 = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0, req_xlate = 1'b0;
    logic [63:0] req_vaddr = '0;
    logic        req_ready, resp_valid, resp_err, resp_dev;
    logic [39:0] resp_addr;
    logic [7:0]  resp_dev_id;
    logic [31:0] resp_dev_off;
    logic [23:0] resp_ppn;
    logic        sp_req_valid, sp_req_write, sp_req_xlate;
    logic [63:0] sp_req_vaddr;
    logic        sp_rsp_valid = 1'b0, sp_rsp_fail = 1'b0, sp_rsp_dev = 1'b0, sp_rsp_cow = 1'b0;
    logic [39:0] sp_rsp_host = '0;
    logic [23:0] sp_rsp_gppn = '0;

    int n_checks = 0;
    int n_errors = 0;

    // Slow-path answer for the next miss
    logic        m_fail, m_dev, m_cow;
    logic [39:0] m_host;
    logic [23:0] m_gppn;

    // Captured response
    logic        got_miss, g_err, g_dev;
    logic [39:0] g_addr;
    logic [7:0]  g_id;
    logic [31:0] g_off;
    logic [23:0] g_ppn;

    always #10 clk = ~clk;

    xlate_cache dut_i (.*);

    localparam logic [63:0] VA_A = 64'h0000_0000_0040_1234;
    localparam logic [63:0] VA_B = 64'h0000_0000_0123_4000;
    localparam logic [63:0] VA_C = 64'h0000_0000_0080_3010;
    localparam logic [63:0] VA_D = 64'h0000_0000_00C0_5044;
    localparam logic [63:0] VA_E = 64'h0000_0000_0200_6000;
    localparam logic [63:0] VA_F = 64'h0000_0100_0040_1234;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic set_model(input bit fail, input logic [39:0] host,
                             input logic [23:0] gppn, input bit dev, input bit cow);
        m_fail = fail; m_host = host; m_gppn = gppn; m_dev = dev; m_cow = cow;
    endtask

    task automatic access(input logic [63:0] va, input bit wr, input bit xl,
                          input bit exp_miss, input string req);
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_write = wr; req_xlate = xl;
        @(negedge clk);
        req_valid = 1'b0;
        got_miss = sp_req_valid;
        chk(got_miss == exp_miss, req, "miss", 64'(got_miss), 64'(exp_miss));
        if (got_miss) begin
            chk(sp_req_vaddr == va && sp_req_write == wr && sp_req_xlate == xl,
                "R4", "slow request fields", {sp_req_vaddr[61:0], sp_req_write, sp_req_xlate},
                {va[61:0], wr, xl});
            chk(!req_ready && !resp_valid, "R10", "busy while waiting",
                64'({req_ready, resp_valid}), 64'd0);
            @(negedge clk);
            chk(sp_req_valid && !resp_valid, "R4", "request held", 64'({sp_req_valid, resp_valid}), 64'd2);
            sp_rsp_valid = 1'b1; sp_rsp_fail = m_fail; sp_rsp_host = m_host;
            sp_rsp_gppn = m_gppn; sp_rsp_dev = m_dev; sp_rsp_cow = m_cow;
            @(negedge clk);
            sp_rsp_valid = 1'b0;
        end
        chk(resp_valid, req, "response strobe", 64'(resp_valid), 64'd1);
        g_err = resp_err; g_dev = resp_dev; g_addr = resp_addr;
        g_id = resp_dev_id; g_off = resp_dev_off; g_ppn = resp_ppn;
        @(negedge clk);
        chk(!resp_valid, req, "response one cycle", 64'(resp_valid), 64'd0);
    endtask

    task automatic write_mode(input bit wide);
        @(negedge clk); mode_wr = 1'b1; mode_sel64 = wide;
        @(negedge clk); mode_wr = 1'b0;
    endtask

    task automatic t_reset;
        chk(req_ready && !resp_valid && !sp_req_valid, "R1", "reset outputs",
            64'({req_ready, resp_valid, sp_req_valid}), 64'd4);
        set_model(0, 40'h12_3456_7000, 24'h0ABCDE, 0, 0);
        access(VA_A, 0, 0, 1, "R1");
        chk(g_addr == 40'h12_3456_7234 && !g_err && !g_dev, "R4", "refill address",
            g_addr, 40'h12_3456_7234);
    endtask

    task automatic t_hit;
        access(VA_A + 64'h333, 0, 0, 0, "R2");
        chk(g_addr == 40'h12_3456_7567, "R2", "hit address", g_addr, 40'h12_3456_7567);
        access(VA_A, 1, 0, 0, "R2");
        chk(g_addr == 40'h12_3456_7234, "R2", "write hit address", g_addr, 40'h12_3456_7234);
    endtask

    task automatic t_xlate;
        access(VA_A, 0, 1, 0, "R7");
        chk(g_ppn == 24'h0ABCDE && g_addr == 0 && !g_dev, "R7", "ppn on hit", g_ppn, 24'h0ABCDE);
        set_model(0, 40'h00_0777_0000, 24'h123456, 0, 0);
        access(VA_B, 0, 1, 1, "R7");
        chk(g_ppn == 24'h123456 && g_addr == 0, "R7", "ppn on refill", g_ppn, 24'h123456);
        access(VA_B, 0, 1, 0, "R7");
        chk(g_ppn == 24'h123456, "R7", "ppn after refill", g_ppn, 24'h123456);
    endtask

    task automatic t_cow;
        set_model(0, 40'h33_0000_0000, 24'h000111, 0, 1);
        access(VA_C, 0, 0, 1, "R3");
        access(VA_C, 0, 0, 0, "R3");
        chk(g_addr == 40'h33_0000_0010, "R3", "read hits cow slot", g_addr, 40'h33_0000_0010);
        set_model(0, 40'h44_0000_0000, 24'h000222, 0, 0);
        access(VA_C, 1, 0, 1, "R3");
        chk(g_addr == 40'h44_0000_0010, "R3", "cow write refill", g_addr, 40'h44_0000_0010);
        access(VA_C, 1, 0, 0, "R3");
        chk(g_addr == 40'h44_0000_0010, "R3", "write hits after copy", g_addr, 40'h44_0000_0010);
    endtask

    task automatic t_device;
        set_model(0, 40'h5A_0000_1230, 24'h000333, 1, 0);
        access(VA_D, 0, 0, 1, "R6");
        chk(g_dev && g_id == 8'h5A && g_off == 32'h0000_1230 && g_addr == 0, "R6",
            "device split refill", {g_id, g_off}, {8'h5A, 32'h0000_1230});
        access(VA_D, 1, 0, 0, "R6");
        chk(g_dev && g_id == 8'h5A && g_off == 32'h0000_1230 && g_addr == 0, "R6",
            "device split hit", {g_id, g_off}, {8'h5A, 32'h0000_1230});
    endtask

    task automatic t_fail;
        set_model(1, 40'h66_0000_0000, 24'h000444, 0, 0);
        access(VA_E, 0, 0, 1, "R5");
        chk(g_err && g_addr == 0 && !g_dev && g_ppn == 0, "R5", "error response",
            {g_err, g_dev, g_addr}, {1'b1, 1'b0, 40'h0});
        set_model(0, 40'h66_0000_0000, 24'h000444, 0, 0);
        access(VA_E, 0, 0, 1, "R5");
        chk(!g_err && g_addr == 40'h66_0000_0000, "R5", "retry after fail", g_addr, 40'h66_0000_0000);
    endtask

    task automatic t_alias;
        set_model(0, 40'h77_0000_0000, 24'h000555, 0, 0);
        access(VA_F, 0, 0, 1, "R11");
        chk(g_addr == 40'h77_0000_0234, "R11", "alias refill", g_addr, 40'h77_0000_0234);
        set_model(0, 40'h12_3456_7000, 24'h0ABCDE, 0, 0);
        access(VA_A, 0, 0, 1, "R11");
        access(VA_F, 0, 0, 1, "R8");
    endtask

    task automatic t_mode;
        set_model(0, 40'h12_3456_7000, 24'h0ABCDE, 0, 0);
        access(VA_A, 0, 0, 1, "R11");
        write_mode(1'b1);
        access(VA_A, 0, 0, 0, "R9");
        write_mode(1'b0);
        set_model(0, 40'h22_0000_1000, 24'h000666, 0, 0);
        access(VA_A, 0, 0, 1, "R9");
        access(VA_A | 64'hFFFF_FFFF_0000_0000, 0, 0, 0, "R8");
        chk(g_addr == 40'h22_0000_1234, "R8", "narrow mode hit", g_addr, 40'h22_0000_1234);
        write_mode(1'b0);
        access(VA_A, 0, 0, 0, "R9");
        write_mode(1'b1);
        access(VA_A, 0, 0, 1, "R9");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_hit();
        t_xlate();
        t_cow();
        t_device();
        t_fail();
        t_alias();
        t_mode();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule